// File: doc/BRIEF.md
# Masked-Write Card Clock Generator

This block produces the interface clock for a memory-card host. A 16-bit configuration word holds a 7-bit divide value N and a source-select bit. The select bit picks one of two source clocks: a fixed 24 MHz reference or a faster PLL clock. The chosen source is divided by N+1, and a fixed halving stage follows. The output clock therefore runs at the source rate divided by 2×(N+1).

Low rates, such as the 400 kHz identification clock, are out of reach of the PLL path within 128 divide steps, so software selects the reference source for them. Writes carry a per-bit enable mask in the upper half of the 32-bit write word. Fields can therefore be changed without a read-modify-write.

The block runs on one core clock. Each source clock is presented as a one-cycle strobe (`ref_tick`, `pll_tick`) marking that source's rising edge. The output is a register, so it cannot glitch.

A two-state machine generates the output:
- **PH_LOW**: the output is low and the machine counts ticks of the active source.
- **PH_HIGH**: the output is high and the machine counts in the same way.

There are two transitions:
- **LOW→HIGH (rise)**: taken on the (N+1)-th tick. On this transition the configured divider and source are copied into the active settings.
- **HIGH→LOW (fall)**: taken on the (N+1)-th tick, with no reload.

New settings therefore take effect only at a period boundary, and no shortened pulse is produced.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the configuration is 0x0000, `rd_data` reads 0 and `clk_out` is low. The active settings are the reference source with N=0.
- R2: On a write, configuration bit i (0..15) takes `wr_data[i]` only when `wr_data[16+i]` is 1; otherwise it keeps its value.
- R3: `rd_data` returns the configuration in bits [15:0] and zero in bits [31:16]. Without a write it does not change.
- R4: The divide value N is configuration bits [6:0]. The source select is bit 8 (0 = reference, 1 = PLL). The remaining bits are stored and read back but do not affect the clock.
- R5: Each high phase and each low phase of `clk_out` lasts exactly N+1 ticks of the active source, so the output frequency is source/(2×(N+1)) with 50% duty.
- R6: With N=0 the output toggles on every tick of the active source.
- R7: With N=127 (the largest value) each phase lasts 128 ticks.
- R8: New settings are applied only at a rising edge of `clk_out`. A period already under way completes with the old settings.
- R9: `clk_out` changes only in the cycle after a tick of the active source. Ticks of the other source have no effect.
- R10: A write whose mask half is all zero changes neither the read-back value nor the output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 32 | [31:16] per-bit write enables, [15:0] new bit values |
| rd_data | output | 32 | Configuration read-back, upper half zero |
| ref_tick | input | 1 | One-cycle strobe per reference-clock edge |
| pll_tick | input | 1 | One-cycle strobe per PLL-clock edge |
| clk_out | output | 1 | Divided card interface clock |

## Verification
The assertions assume each tick strobe lasts one core cycle per source edge and is synchronous to `clk`. They also assume a write is one cycle of `wr_en` with a stable word. The bench drives both strobes from free-running counters of coprime spacing, so the sources tick at different rates and sometimes together. It asserts `wr_en` for exactly one cycle per write, and places one write in the middle of a high phase to exercise deferred application. Phase lengths are measured in ticks of the expected source while the other source keeps ticking.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int CFG_W_DEF   = 16;
    localparam int DIV_W_DEF   = 7;
    localparam int SEL_POS_DEF = 8;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef enum logic {
        SRC_REF = 1'b0,
        SRC_PLL = 1'b1
    } src_e;
endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg #(
    parameter int CFG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2*CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0]   cfg
);
    logic [CFG_W-1:0] bit_en;
    logic [CFG_W-1:0] bit_val;
    logic [CFG_W-1:0] cfg_next;

    assign bit_en  = wr_data[2*CFG_W-1:CFG_W];
    assign bit_val = wr_data[CFG_W-1:0];

    // Each bit updates independently under its own enable
    for (genvar i = 0; i < CFG_W; i++) begin : g_bit
        assign cfg_next[i] = bit_en[i] ? bit_val[i] : cfg[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr_en)
            cfg <= cfg_next;
    end
endmodule

// File: rtl/sdclk_src_mux.sv
module sdclk_src_mux
    import sdclk_pkg::*;
(
    input  logic ref_tick,
    input  logic pll_tick,
    input  src_e sel,
    output logic tick
);
    // Select is only updated at an output boundary, so switching is clean
    always_comb begin
        unique case (sel)
            SRC_REF: tick = ref_tick;
            SRC_PLL: tick = pll_tick;
        endcase
    end
endmodule

// File: rtl/sdclk_toggle_fsm.sv
module sdclk_toggle_fsm
    import sdclk_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] new_div,
    input  src_e             new_src,
    output logic [DIV_W-1:0] act_div,
    output src_e             act_src,
    output logic             clk_out
);
    phase_e           state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             terminal;
    logic             rise;

    assign terminal = tick && (cnt_q == act_div);
    assign rise     = (state_q == PH_LOW) && terminal;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (terminal) state_d = PH_HIGH;
            PH_HIGH: if (terminal) state_d = PH_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PH_LOW;
        else
            state_q <= state_d;
    end

    // Tick counter within the current phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (terminal)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Active settings reload only on the rising transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_div <= '0;
            act_src <= SRC_REF;
        end else if (rise) begin
            act_div <= new_div;
            act_src <= new_src;
        end
    end

    // Output decode from state register
    always_comb begin
        unique case (state_q)
            PH_LOW:  clk_out = 1'b0;
            PH_HIGH: clk_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int CFG_W   = CFG_W_DEF,
    parameter int DIV_W   = DIV_W_DEF,
    parameter int SEL_POS = SEL_POS_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2*CFG_W-1:0] wr_data,
    output logic [2*CFG_W-1:0] rd_data,
    input  logic               ref_tick,
    input  logic               pll_tick,
    output logic               clk_out
);
    logic [CFG_W-1:0] cfg;
    logic [DIV_W-1:0] act_div;
    src_e             act_src;
    src_e             cfg_src;
    logic             tick;

    sdclk_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    assign rd_data = {{CFG_W{1'b0}}, cfg};
    assign cfg_src = src_e'(cfg[SEL_POS]);

    sdclk_src_mux u_mux (
        .ref_tick (ref_tick),
        .pll_tick (pll_tick),
        .sel      (act_src),
        .tick     (tick)
    );

    sdclk_toggle_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .new_div (cfg[DIV_W-1:0]),
        .new_src (cfg_src),
        .act_div (act_div),
        .act_src (act_src),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
    parameter int CFG_W = 16,
    parameter int DIV_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [2*CFG_W-1:0] wr_data,
    input logic [2*CFG_W-1:0] rd_data,
    input logic               ref_tick,
    input logic               pll_tick,
    input logic               clk_out,
    input logic [DIV_W-1:0]   act_div,
    input logic               act_src
);
    assert_rd_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2*CFG_W-1:CFG_W] == '0);

    assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[CFG_W-1:0] ==
            (($past(rd_data[CFG_W-1:0]) & ~$past(wr_data[2*CFG_W-1:CFG_W])) |
             ($past(wr_data[CFG_W-1:0]) & $past(wr_data[2*CFG_W-1:CFG_W]))));

    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    assert_toggle_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_out) |-> ($past(act_src) ? $past(pll_tick) : $past(ref_tick)));

    assert_apply_at_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(clk_out) |-> ($stable(act_div) && $stable(act_src)));
endmodule

bind sdclk_gen sdclk_gen_chk #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .ref_tick (ref_tick),
    .pll_tick (pll_tick),
    .clk_out  (clk_out),
    .act_div  (act_div),
    .act_src  (act_src)
);

// File: tb/sdclk_gen_test.sv
module sdclk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ref_tick = 1'b0;
    logic        pll_tick = 1'b0;
    logic        clk_out;

    always #2 clk = ~clk;   // 250 MHz

    sdclk_gen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .ref_tick (ref_tick),
        .pll_tick (pll_tick),
        .clk_out  (clk_out)
    );

    typedef struct {
        logic  lvl;
        logic  src;
        int    cnt;
        string req;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] cfg_m = '0;
    int          gcnt = 0;
    int          ref_cnt = 0;
    int          pll_cnt = 0;
    logic        prev_out = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Tick generator and phase monitor (scoreboard consumer)
    always @(negedge clk) begin
        if (rst_n) begin
            ref_cnt += int'(ref_tick);
            pll_cnt += int'(pll_tick);
            if (clk_out !== prev_out) begin
                if (exp_q.size() > 0 && exp_q[0].lvl == prev_out) begin
                    exp_t e;
                    int   act;
                    e   = exp_q.pop_front();
                    act = e.src ? pll_cnt : ref_cnt;
                    check(act == e.cnt, e.req, act, e.cnt);
                end
                ref_cnt = 0;
                pll_cnt = 0;
            end
            prev_out = clk_out;
        end
        gcnt++;
        ref_tick = (gcnt % 7 == 0);
        pll_tick = (gcnt % 3 == 1);
    end

    task automatic wr(input logic [15:0] mask, input logic [15:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {mask, data};
        @(negedge clk);
        wr_en   = 1'b0;
        cfg_m   = (cfg_m & ~mask) | (data & mask);
        check(rd_data == {16'h0, cfg_m}, "R2", int'(rd_data), int'({16'h0, cfg_m}));
    endtask

    // Driver: at the next rise the new settings are live; push both phases
    task automatic arm(input string req);
        exp_t e;
        @(posedge clk_out);
        e.src = cfg_m[8];
        e.cnt = int'(cfg_m[6:0]) + 1;
        e.req = req;
        e.lvl = 1'b1;
        exp_q.push_back(e);
        e.lvl = 1'b0;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic prog(input logic [15:0] mask, input logic [15:0] data, input string req);
        wr(mask, data);
        arm(req);
        drain();
    endtask

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        check(rd_data == 32'h0, "R1", int'(rd_data), 0);
        check(clk_out == 1'b0, "R1", int'(clk_out), 0);
        rst_n = 1'b1;

        arm("R1");                       // reset: reference source, N=0
        drain();

        prog(16'hFFFF, 16'h0000, "R6");  // N=0 reference
        prog(16'hFFFF, 16'h0103, "R9");  // N=3 PLL, reference ticks ignored
        prog(16'hFFFF, 16'h0004, "R5");  // odd ratio 5 on reference
        prog(16'hFFFF, 16'h007F, "R7");  // largest divide

        // Mask of zero: no effect on value or timing
        snap = rd_data;
        wr(16'h0000, 16'hFFFF);
        check(rd_data == snap, "R10", int'(rd_data), int'(snap));
        arm("R10");
        drain();

        prog(16'h0100, 16'hFFFF, "R4");  // flip only select bit -> PLL, N kept
        prog(16'h807F, 16'h8002, "R3");  // spare bit 15 stored, N=2

        // Hold without writes
        snap = rd_data;
        repeat (20) @(negedge clk);
        check(rd_data == snap, "R3", int'(rd_data), int'(snap));
        check(rd_data[31:16] == 16'h0, "R3", int'(rd_data[31:16]), 0);

        // Change mid-period: the running period keeps the old settings
        wr(16'hFFFF, 16'h0005);
        arm("R8");
        repeat (4) @(negedge clk);
        wr(16'hFFFF, 16'h0101);
        arm("R8");
        drain();

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R5 actual=%0d expected=%0d", exp_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule